// File: doc/BRIEF.md
# DDR write calibration pattern checker

This block steps through the byte lanes of a DDR3 write path one at a time and decides whether each lane's write timing is right. For the current lane it asks the memory side to write a known burst and read it back. It stores the eight returned bytes and compares them with the expected burst and with shifted copies of that burst. A shifted copy shows that the write lands one or two clock cycles early, or one cycle late. Depending on the result, the block moves to the next lane, asks the write leveling logic for a clock shift and tries again, asks for the lane's read delay taps to be cleared, or stops with an error.

The written sequence is twelve bytes long: FF 00 AA 55 55 AA 99 66 BB 11 EE 44. A correct lane returns the first eight of these. A lane that is one cycle early returns the window that starts at the third byte. A lane that is two cycles early returns the window that starts at the fifth byte. A lane that is one cycle late returns the first six bytes in its last six beats. The delay elements, the command path and the leveling engine all sit outside the block. Each of them is reached through a request/acknowledge pair.

The state machine has seven states:
- IDLE: the state after reset.
- REQ: wait for the readback.
- CHECK: classify the stored burst.
- SHIFT: wait for the clock shift.
- TAPCLR: wait for the taps to be cleared.
- DONE: every lane matched.
- FAIL: calibration stopped with an error.

It has these transitions:
- IDLE, DONE or FAIL to REQ on a start pulse.
- REQ to CHECK on the readback acknowledge.
- CHECK to REQ on a match when the lane is not the last one.
- CHECK to DONE on a match at the last lane.
- CHECK to SHIFT on an early result.
- SHIFT to REQ on the shift acknowledge.
- CHECK to TAPCLR on an unrecognized burst while tries remain.
- TAPCLR to REQ on the tap-clear acknowledge.
- CHECK to FAIL on a late result, or on the unrecognized burst that uses up the last try.

Top module: `wrcal_seq`

## Requirements
- R1: After reset the block is in IDLE. All request outputs, flags and `attempt` are 0, and `lane_idx` is 0.
- R2: `cal_start` is accepted only in IDLE, DONE or FAIL. It clears `cal_done`, `cal_err`, `lane_idx`, `attempt`, `pat_match`, `early1` and `early2`, and it enters REQ. A pulse while `cal_active` is high has no effect.
- R3: `wr_rd_req` stays high until a cycle with `wr_rd_ack` high. In that cycle `rd_burst` is stored, with beat k (rise0, fall0, rise1, …) in bits [8k+7:8k]. The stored burst clears `pat_match`, `early1` and `early2`. At most one of `wr_rd_req`, `shift_req` and `tap_clr_req` is high at a time.
- R4: A burst of FF 00 AA 55 55 AA 99 66 (beats 0 to 7) is a match. A match sets `pat_match` and inverts `pat_match_tgl`. It then advances `lane_idx` by one, clears `attempt` and issues a new readback. At lane DQS_WIDTH-1 a match instead asserts `cal_done`, and `lane_idx` holds that value.
- R5: A burst of 55 AA 99 66 BB 11 EE 44 sets `early2` and raises `shift_req` with `shift_amt`=2. After `shift_ack`, `attempt` clears and the same lane is read again.
- R6: A burst of AA 55 55 AA 99 66 BB 11 sets `early1` and raises `shift_req` with `shift_amt`=1. After `shift_ack`, `attempt` clears and the same lane is read again.
- R7: A burst whose beats 2 to 7 are FF 00 AA 55 55 AA, with any bytes in beats 0 and 1, asserts `cal_err` and enters FAIL. `cal_done` stays 0.
- R8: Any other burst increments `attempt` and raises `tap_clr_req` for the lane in `lane_idx`. After `tap_ack` the same lane is read again.
- R9: `attempt` never exceeds MAX_TRIES (default 31). The unrecognized burst that brings it to MAX_TRIES asserts `cal_err` and enters FAIL without raising `tap_clr_req`.
- R10: `cal_done` and `cal_err` are never high together. `cal_active` is high exactly in REQ, CHECK, SHIFT and TAPCLR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start pulse |
| wr_rd_req | output | 1 | Request a pattern write and readback of the current lane |
| wr_rd_ack | input | 1 | Readback complete; `rd_burst` valid |
| rd_burst | input | 64 | Eight readback bytes, beat k in bits [8k+7:8k] |
| shift_req | output | 1 | Request a write clock shift |
| shift_amt | output | 2 | Shift amount in cycles (1 or 2) |
| shift_ack | input | 1 | Clock shift done |
| tap_clr_req | output | 1 | Request that the current lane's DQ delay taps be set to 0 |
| tap_ack | input | 1 | Tap clear done |
| lane_idx | output | $clog2(DQS_WIDTH) | Lane under calibration |
| cal_active | output | 1 | Calibration in progress |
| cal_done | output | 1 | All lanes matched |
| cal_err | output | 1 | Calibration failed |
| pat_match | output | 1 | The last burst matched |
| pat_match_tgl | output | 1 | Inverts on every match |
| early1 | output | 1 | The last burst was one cycle early |
| early2 | output | 1 | The last burst was two cycles early |
| attempt | output | $clog2(MAX_TRIES+1) | Count of unrecognized bursts on this lane |

## Verification
The bench aims at the classification boundaries:
- A late burst with arbitrary leading bytes must fail. A design that compared all eight bytes would treat it as unrecognized and clear the taps instead.
- Early results of one and of two cycles come in a mixed order. Swapped pattern windows would show up as a wrong `shift_amt`.
- Unknown bursts come before a lane advance. This checks that `attempt` clears on the advance.
- A full run of unrecognized bursts must end in FAIL at exactly MAX_TRIES with one tap clear fewer. An off-by-one limit would give one try too many or too few.
- A start pulse arrives while the block is busy, and another arrives after a failure. A design that restarted mid-run would consume extra readbacks and end on the wrong lane. One that kept the old error would show `cal_err` after the restart.

// File: rtl/wrcal_pkg.sv
package wrcal_pkg;

    localparam int BYTE_W  = 8;
    localparam int BEATS   = 8;
    localparam int BURST_W = BYTE_W * BEATS;
    localparam int SEQ_LEN = 12;
    localparam int SEQ_W   = BYTE_W * SEQ_LEN;

    // full written sequence, first byte in the low bits
    localparam logic [SEQ_W-1:0] WR_SEQ = 96'h44EE11BB6699AA5555AA00FF;

    // number of leading bytes a late lane loses
    localparam int LATE_SKIP = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CHECK,
        ST_SHIFT,
        ST_TAPCLR,
        ST_DONE,
        ST_FAIL
    } wrcal_state_t;

    typedef enum logic [2:0] {
        CL_MATCH,
        CL_EARLY1,
        CL_EARLY2,
        CL_LATE,
        CL_NONE
    } wrcal_class_t;

    // eight-beat window of the written sequence starting at byte offset
    function automatic logic [BURST_W-1:0] seq_window(input int offset);
        return WR_SEQ[offset*BYTE_W +: BURST_W];
    endfunction

endpackage

// File: rtl/wrcal_capture.sv
module wrcal_capture #(
    parameter int BURST_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BURST_W-1:0] din,
    output logic [BURST_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/wrcal_classify.sv
module wrcal_classify
    import wrcal_pkg::*;
(
    input  logic [BURST_W-1:0] burst,
    output wrcal_class_t       cls
);

    localparam logic [BURST_W-1:0] PAT_GOOD   = seq_window(0);
    localparam logic [BURST_W-1:0] PAT_EARLY1 = seq_window(2);
    localparam logic [BURST_W-1:0] PAT_EARLY2 = seq_window(4);
    localparam int                 TAIL_W     = BURST_W - LATE_SKIP*BYTE_W;
    localparam logic [TAIL_W-1:0]  PAT_LATE   = PAT_GOOD[TAIL_W-1:0];

    logic hit_good, hit_e1, hit_e2, hit_late;

    always_comb begin
        hit_good = (burst == PAT_GOOD);
        hit_e1   = (burst == PAT_EARLY1);
        hit_e2   = (burst == PAT_EARLY2);
        hit_late = (burst[BURST_W-1 -: TAIL_W] == PAT_LATE);
        if (hit_good)      cls = CL_MATCH;
        else if (hit_e2)   cls = CL_EARLY2;
        else if (hit_e1)   cls = CL_EARLY1;
        else if (hit_late) cls = CL_LATE;
        else               cls = CL_NONE;
    end

endmodule

// File: rtl/wrcal_try_cnt.sv
module wrcal_try_cnt #(
    parameter int MAX_TRIES = 31,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             last_try
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_TRIES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_TRIES - 1);

    assign last_try = (count == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wrcal_seq.sv
module wrcal_seq
    import wrcal_pkg::*;
#(
    parameter int DQS_WIDTH = 8,
    parameter int MAX_TRIES = 31,
    parameter int LANE_W    = $clog2(DQS_WIDTH),
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cal_start,
    output logic               wr_rd_req,
    input  logic               wr_rd_ack,
    input  logic [BURST_W-1:0] rd_burst,
    output logic               shift_req,
    output logic [1:0]         shift_amt,
    input  logic               shift_ack,
    output logic               tap_clr_req,
    input  logic               tap_ack,
    output logic [LANE_W-1:0]  lane_idx,
    output logic               cal_active,
    output logic               cal_done,
    output logic               cal_err,
    output logic               pat_match,
    output logic               pat_match_tgl,
    output logic               early1,
    output logic               early2,
    output logic [CNT_W-1:0]   attempt
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(DQS_WIDTH - 1);

    wrcal_state_t       state_q, state_d;
    wrcal_class_t       cls;
    logic [BURST_W-1:0] burst_q;
    logic               start_ok, capture, last_try;
    logic               try_clr, try_inc;

    assign start_ok = cal_start &&
                      (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
    assign capture  = (state_q == ST_REQ) && wr_rd_ack;

    wrcal_capture #(.BURST_W(BURST_W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (capture),
        .din  (rd_burst),
        .dout (burst_q)
    );

    wrcal_classify u_cls (
        .burst(burst_q),
        .cls  (cls)
    );

    always_comb begin
        try_clr = start_ok
               || (state_q == ST_SHIFT && shift_ack)
               || (state_q == ST_CHECK && cls == CL_MATCH && lane_idx != LAST_LANE);
        try_inc = (state_q == ST_CHECK && cls == CL_NONE);
    end

    wrcal_try_cnt #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_try (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (try_clr),
        .inc     (try_inc),
        .count   (attempt),
        .last_try(last_try)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (cal_start) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (wr_rd_ack) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                unique case (cls)
                    CL_MATCH:  state_d = (lane_idx == LAST_LANE) ? ST_DONE : ST_REQ;
                    CL_EARLY1,
                    CL_EARLY2: state_d = ST_SHIFT;
                    CL_LATE:   state_d = ST_FAIL;
                    CL_NONE:   state_d = last_try ? ST_FAIL : ST_TAPCLR;
                    default:   state_d = ST_FAIL;
                endcase
            end
            ST_SHIFT: begin
                if (shift_ack) state_d = ST_REQ;
            end
            ST_TAPCLR: begin
                if (tap_ack) state_d = ST_REQ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_idx      <= '0;
            cal_done      <= 1'b0;
            cal_err       <= 1'b0;
            pat_match     <= 1'b0;
            pat_match_tgl <= 1'b0;
            early1        <= 1'b0;
            early2        <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (cal_start) begin
                        lane_idx  <= '0;
                        cal_done  <= 1'b0;
                        cal_err   <= 1'b0;
                        pat_match <= 1'b0;
                        early1    <= 1'b0;
                        early2    <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (wr_rd_ack) begin
                        pat_match <= 1'b0;
                        early1    <= 1'b0;
                        early2    <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    unique case (cls)
                        CL_MATCH: begin
                            pat_match     <= 1'b1;
                            pat_match_tgl <= ~pat_match_tgl;
                            if (lane_idx == LAST_LANE) cal_done <= 1'b1;
                            else                       lane_idx <= lane_idx + 1'b1;
                        end
                        CL_EARLY1: early1  <= 1'b1;
                        CL_EARLY2: early2  <= 1'b1;
                        CL_LATE:   cal_err <= 1'b1;
                        CL_NONE: begin
                            if (last_try) cal_err <= 1'b1;
                        end
                        default: cal_err <= 1'b1;
                    endcase
                end
                ST_SHIFT, ST_TAPCLR: begin
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        wr_rd_req   = (state_q == ST_REQ);
        shift_req   = (state_q == ST_SHIFT);
        tap_clr_req = (state_q == ST_TAPCLR);
        cal_active  = (state_q == ST_REQ) || (state_q == ST_CHECK) ||
                      (state_q == ST_SHIFT) || (state_q == ST_TAPCLR);
        shift_amt   = early2 ? 2'd2 : (early1 ? 2'd1 : 2'd0);
    end

endmodule

// File: rtl/wrcal_seq_chk.sv
module wrcal_seq_chk #(
    parameter int DQS_WIDTH = 8,
    parameter int MAX_TRIES = 31,
    parameter int LANE_W    = $clog2(DQS_WIDTH),
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start,
    input logic              wr_rd_req,
    input logic              wr_rd_ack,
    input logic              shift_req,
    input logic              tap_clr_req,
    input logic [LANE_W-1:0] lane_idx,
    input logic              cal_active,
    input logic              cal_done,
    input logic              cal_err,
    input logic              pat_match,
    input logic              pat_match_tgl,
    input logic              early1,
    input logic              early2,
    input logic [CNT_W-1:0]  attempt
);

    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done && cal_err));

    // R3
    rdreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rd_req && !wr_rd_ack) |=> wr_rd_req);

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_rd_req, shift_req, tap_clr_req}));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && !cal_active) |=> (cal_active && !cal_done && !cal_err && lane_idx == '0));

    // R4
    done_last_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (lane_idx == LANE_W'(DQS_WIDTH - 1)));

    // R4
    tgl_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_match) |-> (pat_match_tgl != $past(pat_match_tgl)));

    // R5
    shift_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_req |-> ($countones({early1, early2}) == 1));

    // R9
    try_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempt <= CNT_W'(MAX_TRIES));

    // R10
    active_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (!cal_done && !cal_err));

endmodule

bind wrcal_seq wrcal_seq_chk #(
    .DQS_WIDTH(DQS_WIDTH),
    .MAX_TRIES(MAX_TRIES),
    .LANE_W   (LANE_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start    (cal_start),
    .wr_rd_req    (wr_rd_req),
    .wr_rd_ack    (wr_rd_ack),
    .shift_req    (shift_req),
    .tap_clr_req  (tap_clr_req),
    .lane_idx     (lane_idx),
    .cal_active   (cal_active),
    .cal_done     (cal_done),
    .cal_err      (cal_err),
    .pat_match    (pat_match),
    .pat_match_tgl(pat_match_tgl),
    .early1       (early1),
    .early2       (early2),
    .attempt      (attempt)
);

// File: tb/test_wrcal_seq.sv
`timescale 1ns/1ps
module test_wrcal_seq;

    localparam int NL = 8;
    localparam int NT = 31;
    localparam logic [63:0] B_GOOD = 64'h6699AA5555AA00FF;
    localparam logic [63:0] B_E1   = 64'h11BB6699AA5555AA;
    localparam logic [63:0] B_E2   = 64'h44EE11BB6699AA55;
    localparam logic [63:0] B_LATE = 64'hAA5555AA00FF7E3C;
    localparam logic [63:0] B_JUNK = 64'h0123456789ABCDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        wr_rd_req, shift_req, tap_clr_req;
    logic        wr_rd_ack = 1'b0, shift_ack = 1'b0, tap_ack = 1'b0;
    logic [63:0] rd_burst = '0;
    logic [1:0]  shift_amt;
    logic [2:0]  lane_idx;
    logic        cal_active, cal_done, cal_err, pat_match, pat_match_tgl, early1, early2;
    logic [4:0]  attempt;

    always #2.5 clk = ~clk;

    wrcal_seq i_wrcal_seq (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .wr_rd_req(wr_rd_req), .wr_rd_ack(wr_rd_ack), .rd_burst(rd_burst),
        .shift_req(shift_req), .shift_amt(shift_amt), .shift_ack(shift_ack),
        .tap_clr_req(tap_clr_req), .tap_ack(tap_ack),
        .lane_idx(lane_idx), .cal_active(cal_active), .cal_done(cal_done),
        .cal_err(cal_err), .pat_match(pat_match), .pat_match_tgl(pat_match_tgl),
        .early1(early1), .early2(early2), .attempt(attempt)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model; states 0 idle 1 req 2 check 3 shift 4 tapclr 5 done 6 fail
    int          m_st = 0, m_lane = 0, m_att = 0;
    int          m_done = 0, m_err = 0, m_match = 0, m_tgl = 0, m_e1 = 0, m_e2 = 0;
    logic [63:0] m_burst = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_lane = 0; m_att = 0; m_done = 0; m_err = 0;
            m_match = 0; m_tgl = 0; m_e1 = 0; m_e2 = 0;
        end else begin
            case (m_st)
                0, 5, 6: if (cal_start) begin
                    m_st = 1; m_lane = 0; m_att = 0; m_done = 0; m_err = 0;
                    m_match = 0; m_e1 = 0; m_e2 = 0;
                end
                1: if (wr_rd_ack) begin
                    m_burst = rd_burst; m_match = 0; m_e1 = 0; m_e2 = 0; m_st = 2;
                end
                2: begin
                    if (m_burst == B_GOOD) begin
                        m_match = 1; m_tgl = 1 - m_tgl;
                        if (m_lane == NL - 1) begin m_done = 1; m_st = 5; end
                        else begin m_lane++; m_att = 0; m_st = 1; end
                    end else if (m_burst == B_E2) begin
                        m_e2 = 1; m_st = 3;
                    end else if (m_burst == B_E1) begin
                        m_e1 = 1; m_st = 3;
                    end else if (m_burst[63:16] == 48'hAA5555AA00FF) begin
                        m_err = 1; m_st = 6;
                    end else begin
                        if (m_att < NT) m_att++;
                        if (m_att == NT) begin m_err = 1; m_st = 6; end
                        else m_st = 4;
                    end
                end
                3: if (shift_ack) begin m_att = 0; m_st = 1; end
                4: if (tap_ack) m_st = 1;
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3", "wr_rd_req", int'(wr_rd_req), int'(m_st == 1));
            check("R5", "shift_req", int'(shift_req), int'(m_st == 3));
            check("R8", "tap_clr_req", int'(tap_clr_req), int'(m_st == 4));
            check("R10", "cal_active", int'(cal_active), int'(m_st >= 1 && m_st <= 4));
            check("R4", "lane_idx", int'(lane_idx), m_lane);
            check("R4", "cal_done", int'(cal_done), m_done);
            check("R7", "cal_err", int'(cal_err), m_err);
            check("R4", "pat_match", int'(pat_match), m_match);
            check("R4", "pat_match_tgl", int'(pat_match_tgl), m_tgl);
            check("R6", "early1", int'(early1), m_e1);
            check("R5", "early2", int'(early2), m_e2);
            check("R9", "attempt", int'(attempt), m_att);
        end
    end

    // responders for the three handshakes
    logic [63:0] rd_q[$];
    int rd_wait = 0, sh_wait = 0, tp_wait = 0;
    int tap_cnt = 0, rd_cnt = 0;
    int shift_log[$];
    logic sh_prev = 1'b0, tp_prev = 1'b0;

    always @(negedge clk) begin
        if (wr_rd_ack) wr_rd_ack = 1'b0;
        else if (rst_n && wr_rd_req) begin
            if (rd_wait == 0) begin
                rd_burst  = (rd_q.size() > 0) ? rd_q.pop_front() : 64'h0;
                wr_rd_ack = 1'b1;
                rd_cnt++;
                rd_wait   = 2;
            end else rd_wait--;
        end
        if (shift_ack) shift_ack = 1'b0;
        else if (rst_n && shift_req) begin
            if (sh_wait == 0) begin shift_ack = 1'b1; sh_wait = 1; end
            else sh_wait--;
        end
        if (tap_ack) tap_ack = 1'b0;
        else if (rst_n && tap_clr_req) begin
            if (tp_wait == 0) begin tap_ack = 1'b1; tp_wait = 1; end
            else tp_wait--;
        end
        if (shift_req && !sh_prev) shift_log.push_back(int'(shift_amt));
        if (tap_clr_req && !tp_prev) tap_cnt++;
        sh_prev = shift_req;
        tp_prev = tap_clr_req;
    end

    task automatic pulse_start();
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_end();
        @(negedge clk);
        while (cal_active) @(negedge clk);
    endtask

    task automatic reset_logs();
        rd_q.delete();
        shift_log.delete();
        tap_cnt = 0;
        rd_cnt  = 0;
    endtask

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int tgl0;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset wr_rd_req", int'(wr_rd_req), 0);
        check("R1", "reset cal_active", int'(cal_active), 0);
        check("R1", "reset lane_idx", int'(lane_idx), 0);
        check("R1", "reset flags", int'({cal_done, cal_err, pat_match, pat_match_tgl, early1, early2}), 0);
        check("R1", "reset attempt", int'(attempt), 0);
        rst_n = 1'b1;

        // R4 all lanes match first time
        reset_logs();
        for (int i = 0; i < NL; i++) rd_q.push_back(B_GOOD);
        tgl0 = int'(pat_match_tgl);
        pulse_start();
        wait_end();
        check("R4", "all match done", int'(cal_done), 1);
        check("R4", "all match lane held", int'(lane_idx), NL - 1);
        check("R4", "toggle parity", int'(pat_match_tgl), tgl0 ^ (NL % 2));
        check("R10", "no error", int'(cal_err), 0);

        // R5 R6 early results in mixed order
        reset_logs();
        rd_q.push_back(B_GOOD);
        rd_q.push_back(B_E2); rd_q.push_back(B_GOOD);
        rd_q.push_back(B_E1); rd_q.push_back(B_GOOD);
        rd_q.push_back(B_E1); rd_q.push_back(B_E2); rd_q.push_back(B_GOOD);
        for (int i = 0; i < NL - 3; i++) rd_q.push_back(B_GOOD);
        pulse_start();
        wait_end();
        check("R5", "shift count", shift_log.size(), 4);
        if (shift_log.size() == 4) begin
            check("R5", "first shift amt", shift_log[0], 2);
            check("R6", "second shift amt", shift_log[1], 1);
            check("R6", "third shift amt", shift_log[2], 1);
            check("R5", "fourth shift amt", shift_log[3], 2);
        end
        check("R5", "early run done", int'(cal_done), 1);

        // R8 unknown bursts then match; attempt must clear on advance
        reset_logs();
        rd_q.push_back(B_JUNK); rd_q.push_back(64'h0); rd_q.push_back(B_JUNK);
        rd_q.push_back(B_GOOD);
        rd_q.push_back(B_JUNK); rd_q.push_back(B_GOOD);
        for (int i = 0; i < NL - 2; i++) rd_q.push_back(B_GOOD);
        pulse_start();
        wait_end();
        check("R8", "tap clear count", tap_cnt, 4);
        check("R8", "retry run done", int'(cal_done), 1);
        check("R9", "attempt after clean last lane", int'(attempt), 0);

        // R7 late on lane 1 with arbitrary leading bytes
        reset_logs();
        rd_q.push_back(B_GOOD);
        rd_q.push_back(B_LATE);
        pulse_start();
        wait_end();
        check("R7", "late error", int'(cal_err), 1);
        check("R7", "late not done", int'(cal_done), 0);
        check("R7", "late lane", int'(lane_idx), 1);
        check("R7", "late no tap clear", tap_cnt, 0);

        // R2 start after fail clears error; start while busy ignored
        reset_logs();
        for (int i = 0; i < NL; i++) rd_q.push_back(B_GOOD);
        pulse_start();
        check("R2", "error cleared by start", int'(cal_err), 0);
        repeat (6) @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        wait_end();
        check("R2", "busy start ignored lane", int'(lane_idx), NL - 1);
        check("R2", "busy start readbacks", rd_cnt, NL);
        check("R2", "busy start done", int'(cal_done), 1);

        // R9 try limit
        reset_logs();
        for (int i = 0; i < NT; i++) rd_q.push_back(B_JUNK ^ 64'(i));
        pulse_start();
        wait_end();
        check("R9", "limit error", int'(cal_err), 1);
        check("R9", "limit attempt", int'(attempt), NT);
        check("R9", "limit tap clears", tap_cnt, NT - 1);
        check("R10", "limit not done", int'(cal_done), 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule